// File: doc/BRIEF.md
# Interrupt Redirection Register Window

This block is the software-facing register file of an interrupt redirection controller. It is reached through a pair of memory-mapped locations. A 32-bit select register chooses one internal register, and a 32-bit data window then reads or writes that register. The internal registers are:

- an identification register;
- a version register;
- an arbitration register that mirrors the identification value;
- a table with one 64-bit redirection entry per interrupt pin, each reached as two 32-bit halves.

A third location accepts end-of-interrupt writes, but only when the block is built as version 0x20.

Dispatch logic sits next to this block. It owns the remote-pending status of each entry and drives it through set and clear vectors. The block tells dispatch about two events: a one-cycle pulse, with the entry index, after every accepted table write, and a one-cycle end-of-interrupt request carrying the written vector. Read data comes back one cycle after the read request, flagged by a valid pulse.

Top module: `redir_regwin`

## Requirements
- R1: Offset 0x00 is the select register. Any write there stores all 32 bits, and a read at 0x00 returns the stored value. It resets to 0.
- R2: The data window at offset 0x10 acts only on 4-byte accesses (busSize = 4). A window read of any other size returns 0, and a window write of any other size changes nothing.
- R3: Select value 0 reaches the identification register and select value 2 the arbitration register. Both read back the 4-bit ID in bits 27:24. Only select 0 can write it, taking it from write bits 27:24. Writes through select 1 or select 2 are ignored. The ID resets to 0.
- R4: Select value 1 reads `VERSION | ((NUM_PINS-1) << 16)`, which is 0x00170020 for version 0x20 with 24 pins.
- R5: For a select value of 0x10 or above, the entry index is (select − 0x10) >> 1. An odd select reaches bits 63:32 of the entry and an even select reaches bits 31:0. An index of NUM_PINS or more reads 0 and ignores writes. Any other select value reads 0.
- R6: A table write replaces the addressed half and keeps only the writable bits. The writable bits are 7:0 vector, 10:8 delivery mode, 11 destination mode, 13 polarity, 15 trigger (1 = level), 16 mask and 63:56 destination. Bits 12 (delivery status) and 14 (remote-pending) keep their previous values. All other bits read 0.
- R7: Remote-pending (bit 14) is set by rpSet[i] and cleared by rpClr[i]. If a table write leaves an entry with trigger bit 15 = 0 (edge), its bit 14 is forced to 0. This holds even when rpSet hits the same entry in the same cycle. A write that leaves the entry in level mode keeps bit 14, OR'd with a same-cycle rpSet.
- R8: After reset, every entry reads 0x00010000 in its lower half (only the mask bit set) and 0 in its upper half.
- R9: After every accepted table write, entryChg is high for exactly the next cycle and chgIndex carries the written entry's index. A write that is not accepted gives no pulse.
- R10: With VERSION = 0x20, a 4-byte write to offset 0x40 raises eoiValid for the next cycle, with eoiVector equal to write bits 7:0. Other sizes, and every such write when VERSION = 0x11, give no request.
- R11: A read request at any offset is answered in the next cycle with rdValid high and the value on busRdata. Offsets other than 0x00 and 0x10 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busValid | input | 1 | Access request this cycle |
| busWrite | input | 1 | 1 = write, 0 = read |
| busAddr | input | 8 | Byte offset of the access |
| busSize | input | 3 | Access size in bytes |
| busWdata | input | 32 | Write data |
| rpSet | input | NUM_PINS | Set remote-pending, one bit per entry |
| rpClr | input | NUM_PINS | Clear remote-pending, one bit per entry |
| busRdata | output | 32 | Read data, valid with rdValid |
| rdValid | output | 1 | Read data valid, one cycle after the request |
| entryChg | output | 1 | Pulse after an accepted table write |
| chgIndex | output | IDX_W | Index of the changed entry |
| eoiValid | output | 1 | End-of-interrupt request pulse |
| eoiVector | output | 8 | Vector carried by the end-of-interrupt request |

## Verification
A software table write and a remote-pending set from dispatch can land on the same entry in the same cycle. The bench provokes this by raising rpSet for that entry inside the very cycle of the window write. It does so twice: once with a level-mode value, where bit 14 must read back as 1, and once with an edge-mode value, where the forced clear must win and bit 14 must read back as 0. Each result is judged by reading the lower half back through the window.

// File: rtl/regwin_pkg.sv
package regwin_pkg;
  localparam logic [7:0] OFS_SEL = 8'h00;
  localparam logic [7:0] OFS_WIN = 8'h10;
  localparam logic [7:0] OFS_EOI = 8'h40;
  localparam logic [2:0] FULL_SIZE = 3'd4;
  localparam logic [31:0] TBL_BASE = 32'h10;
  localparam int ID_SHIFT = 24;
  localparam int ID_W = 4;
  localparam int VER_ENT_SHIFT = 16;
  localparam int DS_BIT = 12;
  localparam int RP_BIT = 14;
  localparam int TRIG_BIT = 15;
  localparam logic [63:0] RW_MASK = 64'hFF00_0000_0001_AFFF;
  localparam logic [63:0] RO_MASK = (64'd1 << DS_BIT) | (64'd1 << RP_BIT);
  localparam logic [63:0] ENTRY_RST = 64'h0000_0000_0001_0000;

  typedef enum logic [2:0] {
    SRC_ZERO, SRC_SEL, SRC_ID, SRC_VER, SRC_TLO, SRC_THI
  } rdSrc_t;

  typedef struct packed {
    logic selWr;
    logic idWr;
    logic tblWr;
    logic tblHi;
    logic eoiWr;
    logic rdReq;
  } winStrb_t;
endpackage

// File: rtl/regwin_ctrl.sv
module regwin_ctrl
  import regwin_pkg::*;
#(
  parameter int NUM_PINS = 24,
  parameter int IDX_W = 5,
  parameter bit EOI_EN = 1'b0
) (
  input  logic             busValid,
  input  logic             busWrite,
  input  logic [7:0]       busAddr,
  input  logic [2:0]       busSize,
  input  logic [31:0]      selReg,
  output winStrb_t         strb,
  output logic [IDX_W-1:0] tblIdx,
  output rdSrc_t           rdSrc
);
  logic addrSel, addrWin, addrEoi, sizeOk, inRange;
  logic [31:0] idx32;

  assign addrSel = (busAddr == OFS_SEL);
  assign addrWin = (busAddr == OFS_WIN);
  assign addrEoi = (busAddr == OFS_EOI);
  assign sizeOk  = (busSize == FULL_SIZE);

  // entry index from the select value, with range check
  assign idx32   = (selReg - TBL_BASE) >> 1;
  assign inRange = (selReg >= TBL_BASE) && (idx32 < 32'(NUM_PINS));
  assign tblIdx  = idx32[IDX_W-1:0];

  always_comb begin
    strb = '0;
    if (busValid && busWrite) begin
      strb.selWr = addrSel;
      strb.idWr  = addrWin && sizeOk && (selReg == 32'd0);
      strb.tblWr = addrWin && sizeOk && inRange;
      strb.eoiWr = addrEoi && sizeOk && EOI_EN;
    end
    strb.tblHi = selReg[0];
    strb.rdReq = busValid && !busWrite;
  end

  always_comb begin
    rdSrc = SRC_ZERO;
    if (addrSel) rdSrc = SRC_SEL;
    else if (addrWin && sizeOk) begin
      if (selReg == 32'd0 || selReg == 32'd2) rdSrc = SRC_ID;
      else if (selReg == 32'd1) rdSrc = SRC_VER;
      else if (inRange) rdSrc = selReg[0] ? SRC_THI : SRC_TLO;
    end
  end
endmodule

// File: rtl/regwin_dp.sv
module regwin_dp
  import regwin_pkg::*;
#(
  parameter int NUM_PINS = 24,
  parameter int IDX_W = 5,
  parameter logic [7:0] VERSION = 8'h11
) (
  input  logic                clk,
  input  logic                rstN,
  input  winStrb_t            strb,
  input  logic [IDX_W-1:0]    tblIdx,
  input  rdSrc_t              rdSrc,
  input  logic [31:0]         wdata,
  input  logic [NUM_PINS-1:0] rpSet,
  input  logic [NUM_PINS-1:0] rpClr,
  output logic [31:0]         selReg,
  output logic [31:0]         rdata,
  output logic                rdValid,
  output logic                entryChg,
  output logic [IDX_W-1:0]    chgIndex,
  output logic                eoiValid,
  output logic [7:0]          eoiVector
);
  localparam logic [31:0] VER_WORD = 32'(VERSION) | (32'(NUM_PINS - 1) << VER_ENT_SHIFT);

  logic [ID_W-1:0] idReg;
  logic [NUM_PINS-1:0][63:0] tbl;
  logic [31:0] rdNext;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      selReg <= '0;
      idReg  <= '0;
    end else begin
      if (strb.selWr) selReg <= wdata;
      if (strb.idWr)  idReg  <= wdata[ID_SHIFT +: ID_W];
    end
  end

  for (genvar i = 0; i < NUM_PINS; i++) begin : gEnt
    logic hit;
    logic [63:0] nxt;
    always_comb begin
      hit = strb.tblWr && (tblIdx == IDX_W'(i));
      nxt = tbl[i];
      if (hit) begin
        if (strb.tblHi) nxt[63:32] = wdata;
        else            nxt[31:0]  = wdata;
      end
      nxt = (nxt & RW_MASK) | (tbl[i] & RO_MASK);
      nxt[RP_BIT] = (tbl[i][RP_BIT] | rpSet[i]) & ~rpClr[i];
      if (hit && !nxt[TRIG_BIT]) nxt[RP_BIT] = 1'b0;
    end
    always_ff @(posedge clk) begin
      if (!rstN) tbl[i] <= ENTRY_RST;
      else       tbl[i] <= nxt;
    end
  end

  always_comb begin
    case (rdSrc)
      SRC_SEL: rdNext = selReg;
      SRC_ID:  rdNext = 32'(idReg) << ID_SHIFT;
      SRC_VER: rdNext = VER_WORD;
      SRC_TLO: rdNext = tbl[tblIdx][31:0];
      SRC_THI: rdNext = tbl[tblIdx][63:32];
      default: rdNext = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdata     <= '0;
      rdValid   <= 1'b0;
      entryChg  <= 1'b0;
      chgIndex  <= '0;
      eoiValid  <= 1'b0;
      eoiVector <= '0;
    end else begin
      rdValid  <= strb.rdReq;
      if (strb.rdReq) rdata <= rdNext;
      entryChg <= strb.tblWr;
      if (strb.tblWr) chgIndex <= tblIdx;
      eoiValid <= strb.eoiWr;
      if (strb.eoiWr) eoiVector <= wdata[7:0];
    end
  end

  // checker support: index of the previous cycle
  logic [IDX_W-1:0] lastIdx;
  always_ff @(posedge clk) lastIdx <= tblIdx;

  AST_EDGE_CLEARS_RP: assert property (@(posedge clk) disable iff (!rstN)
    strb.tblWr |=> !(!tbl[lastIdx][TRIG_BIT] && tbl[lastIdx][RP_BIT])); // R7
  AST_SEL_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    !strb.selWr |=> $stable(selReg)); // R1
  AST_ID_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    !strb.idWr |=> $stable(idReg)); // R3
  AST_CHG_FOLLOWS: assert property (@(posedge clk) disable iff (!rstN)
    strb.tblWr |=> (entryChg && chgIndex == lastIdx)); // R9
endmodule

// File: rtl/redir_regwin.sv
module redir_regwin
  import regwin_pkg::*;
#(
  parameter int NUM_PINS = 24,
  parameter logic [7:0] VERSION = 8'h11,
  localparam int IDX_W = $clog2(NUM_PINS)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                busValid,
  input  logic                busWrite,
  input  logic [7:0]          busAddr,
  input  logic [2:0]          busSize,
  input  logic [31:0]         busWdata,
  input  logic [NUM_PINS-1:0] rpSet,
  input  logic [NUM_PINS-1:0] rpClr,
  output logic [31:0]         busRdata,
  output logic                rdValid,
  output logic                entryChg,
  output logic [IDX_W-1:0]    chgIndex,
  output logic                eoiValid,
  output logic [7:0]          eoiVector
);
  localparam bit EOI_EN = (VERSION == 8'h20);

  initial AST_VERSION_LEGAL: assert (VERSION == 8'h11 || VERSION == 8'h20); // R10

  winStrb_t strb;
  logic [IDX_W-1:0] tblIdx;
  rdSrc_t rdSrc;
  logic [31:0] selReg;

  regwin_ctrl #(.NUM_PINS(NUM_PINS), .IDX_W(IDX_W), .EOI_EN(EOI_EN)) uCtrl (
    .busValid(busValid), .busWrite(busWrite), .busAddr(busAddr),
    .busSize(busSize), .selReg(selReg), .strb(strb), .tblIdx(tblIdx),
    .rdSrc(rdSrc)
  );

  regwin_dp #(.NUM_PINS(NUM_PINS), .IDX_W(IDX_W), .VERSION(VERSION)) uDp (
    .clk(clk), .rstN(rstN), .strb(strb), .tblIdx(tblIdx), .rdSrc(rdSrc),
    .wdata(busWdata), .rpSet(rpSet), .rpClr(rpClr), .selReg(selReg),
    .rdata(busRdata), .rdValid(rdValid), .entryChg(entryChg),
    .chgIndex(chgIndex), .eoiValid(eoiValid), .eoiVector(eoiVector)
  );

  AST_EOI_FULL_SIZE: assert property (@(posedge clk) disable iff (!rstN)
    eoiValid |-> ($past(busSize) == FULL_SIZE && $past(busAddr) == OFS_EOI)); // R10
  AST_SHORT_READ_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (rdValid && $past(busAddr) == OFS_WIN && $past(busSize) != FULL_SIZE)
      |-> busRdata == 32'd0); // R2
endmodule

// File: tb/sim_redir_regwin.sv
`timescale 1ns/1ps
module sim_redir_regwin;
  localparam int NP = 24;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic busValid = 1'b0, busWrite = 1'b0;
  logic [7:0] busAddr = '0;
  logic [2:0] busSize = '0;
  logic [31:0] busWdata = '0;
  logic [NP-1:0] rpSet = '0, rpClr = '0;
  logic [31:0] busRdata, rdata1;
  logic rdValid, entryChg, eoiValid, rdValid1, entryChg1, eoiValid1;
  logic [4:0] chgIndex, chgIndex1;
  logic [7:0] eoiVector, eoiVector1;

  int total = 0;
  int fails = 0;

  always #4 clk = ~clk;

  redir_regwin #(.NUM_PINS(NP), .VERSION(8'h20)) u0 (
    .clk(clk), .rstN(rstN), .busValid(busValid), .busWrite(busWrite),
    .busAddr(busAddr), .busSize(busSize), .busWdata(busWdata),
    .rpSet(rpSet), .rpClr(rpClr), .busRdata(busRdata), .rdValid(rdValid),
    .entryChg(entryChg), .chgIndex(chgIndex), .eoiValid(eoiValid),
    .eoiVector(eoiVector));

  redir_regwin #(.NUM_PINS(NP), .VERSION(8'h11)) u1 (
    .clk(clk), .rstN(rstN), .busValid(busValid), .busWrite(busWrite),
    .busAddr(busAddr), .busSize(busSize), .busWdata(busWdata),
    .rpSet(rpSet), .rpClr(rpClr), .busRdata(rdata1), .rdValid(rdValid1),
    .entryChg(entryChg1), .chgIndex(chgIndex1), .eoiValid(eoiValid1),
    .eoiVector(eoiVector1));

  typedef struct { logic [31:0] val; string tag; } expItem_t;
  expItem_t sb[$];

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  // monitor: pops expected read data as the design returns it
  always @(negedge clk) begin
    if (rstN && rdValid) begin
      if (sb.size() == 0) chk(1'b0, "R11 unexpected rdValid", busRdata, 32'd0);
      else begin
        expItem_t e;
        e = sb.pop_front();
        chk(busRdata === e.val, e.tag, busRdata, e.val);
      end
    end
  end

  task automatic busOp(input logic wr, input logic [7:0] a, input logic [2:0] sz,
                       input logic [31:0] d, input logic [NP-1:0] setv);
    @(negedge clk);
    busValid = 1'b1; busWrite = wr; busAddr = a; busSize = sz;
    busWdata = d; rpSet = setv;
    @(negedge clk);
    busValid = 1'b0; busWrite = 1'b0; rpSet = '0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [2:0] sz, input logic [31:0] d);
    busOp(1'b1, a, sz, d, '0);
  endtask

  task automatic rd(input logic [7:0] a, input logic [2:0] sz,
                    input logic [31:0] exp, input string tag);
    expItem_t e;
    e.val = exp; e.tag = tag;
    sb.push_back(e);
    busOp(1'b0, a, sz, 32'd0, '0);
  endtask

  task automatic rdWin(input logic [31:0] sel, input logic [31:0] exp, input string tag);
    wr(8'h00, 3'd4, sel);
    rd(8'h10, 3'd4, exp, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(1'b0, "watchdog expired", 32'd0, 32'd1);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // reset state
    rd(8'h00, 3'd4, 32'd0, "R1 select after reset");
    rdWin(32'h10, 32'h0001_0000, "R8 entry0 low after reset");
    rdWin(32'h11, 32'h0, "R8 entry0 high after reset");
    rdWin(32'h0, 32'h0, "R3 id after reset");

    // select readback
    wr(8'h00, 3'd1, 32'hDEAD_BEEF);
    rd(8'h00, 3'd4, 32'hDEAD_BEEF, "R1 select readback");

    // id, arbitration, version
    wr(8'h00, 3'd4, 32'd0);
    wr(8'h10, 3'd4, 32'hFFFF_FFFF);
    rd(8'h10, 3'd4, 32'h0F00_0000, "R3 id written");
    rdWin(32'd2, 32'h0F00_0000, "R3 arbitration mirrors id");
    wr(8'h10, 3'd4, 32'h0);
    rdWin(32'd0, 32'h0F00_0000, "R3 arbitration write ignored");
    rdWin(32'd1, 32'h0017_0020, "R4 version word");
    chk(rdata1 === 32'h0017_0011, "R4 version word at 0x11", rdata1, 32'h0017_0011);
    wr(8'h10, 3'd4, 32'h0);
    rdWin(32'd1, 32'h0017_0020, "R4 version write ignored");

    // size filter on the window
    wr(8'h00, 3'd4, 32'd0);
    wr(8'h10, 3'd2, 32'h0);
    rd(8'h10, 3'd4, 32'h0F00_0000, "R2 short write ignored");
    rd(8'h10, 3'd2, 32'h0, "R2 short read is zero");
    rd(8'h20, 3'd4, 32'h0, "R11 unmapped offset reads zero");
    rdWin(32'd5, 32'h0, "R5 reserved select reads zero");

    // table merge with writable mask, entry 3
    wr(8'h00, 3'd4, 32'h16);
    wr(8'h10, 3'd4, 32'hFFFF_FFFF);
    chk(entryChg === 1'b1 && chgIndex === 5'd3, "R9 pulse after write",
        {27'd0, chgIndex}, 32'd3);
    @(negedge clk);
    chk(entryChg === 1'b0, "R9 pulse one cycle", {31'd0, entryChg}, 32'd0);
    rd(8'h10, 3'd4, 32'h0001_AFFF, "R6 low half masked");
    wr(8'h00, 3'd4, 32'h17);
    wr(8'h10, 3'd4, 32'hFFFF_FFFF);
    rd(8'h10, 3'd4, 32'hFF00_0000, "R5 R6 upper half masked");

    // remote-pending from dispatch, preserved by level write
    @(negedge clk); rpSet[3] = 1'b1; @(negedge clk); rpSet = '0;
    rdWin(32'h16, 32'h0001_EFFF, "R7 rpSet sets bit14");
    wr(8'h10, 3'd4, 32'h0000_8031);
    rd(8'h10, 3'd4, 32'h0000_C031, "R6 bit14 kept on level write");
    wr(8'h10, 3'd4, 32'h0000_0031);
    rd(8'h10, 3'd4, 32'h0000_0031, "R7 edge write clears bit14");

    // same-cycle write and rpSet
    busOp(1'b1, 8'h10, 3'd4, 32'h0000_8032, NP'(1) << 3);
    rd(8'h10, 3'd4, 32'h0000_C032, "R7 level write with rpSet");
    busOp(1'b1, 8'h10, 3'd4, 32'h0000_0033, NP'(1) << 3);
    rd(8'h10, 3'd4, 32'h0000_0033, "R7 edge write beats rpSet");
    busOp(1'b1, 8'h10, 3'd4, 32'h0000_8034, NP'(1) << 3);
    @(negedge clk); rpClr[3] = 1'b1; @(negedge clk); rpClr = '0;
    rd(8'h10, 3'd4, 32'h0000_8034, "R7 rpClr clears bit14");

    // last entry and out of range
    wr(8'h00, 3'd4, 32'h3E);
    wr(8'h10, 3'd4, 32'h0000_0012);
    chk(entryChg === 1'b1 && chgIndex === 5'd23, "R9 index of last entry",
        {27'd0, chgIndex}, 32'd23);
    rd(8'h10, 3'd4, 32'h0000_0012, "R5 last entry low");
    wr(8'h00, 3'd4, 32'h40);
    wr(8'h10, 3'd4, 32'hFFFF_FFFF);
    chk(entryChg === 1'b0, "R5 R9 out-of-range write no pulse", {31'd0, entryChg}, 32'd0);
    rd(8'h10, 3'd4, 32'h0, "R5 out-of-range reads zero");

    // end of interrupt
    wr(8'h40, 3'd4, 32'h0000_0131);
    chk(eoiValid === 1'b1 && eoiVector === 8'h31, "R10 eoi request",
        {24'd0, eoiVector}, 32'h31);
    chk(eoiValid1 === 1'b0, "R10 eoi ignored at 0x11", {31'd0, eoiValid1}, 32'd0);
    wr(8'h40, 3'd1, 32'h0000_0022);
    chk(eoiValid === 1'b0, "R10 short eoi ignored", {31'd0, eoiValid}, 32'd0);

    repeat (3) @(negedge clk);
    chk(sb.size() == 0, "R11 all reads answered", 32'(sb.size()), 32'd0);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule